// File: doc/BRIEF.md
# Camera Link Base-Configuration Pixel Serializer

This block is the transmit side of a Camera Link base-configuration video link, as seen from the pixel pipeline. Each pixel clock it takes one RGB pixel, three colour channels of up to ten bits each, and four framing flags: frame valid, line valid, data valid and exposure enable. It reduces each channel to eight bits and places the 24 colour bits and the four flags into a 28-bit transmit word. The placement follows the Camera Link allocation, which is not a straight concatenation of the fields. A fast clock running at exactly seven times the pixel rate, phase-locked to it, then moves that word out on four single-ended data lanes. Each lane sends seven bits per pixel period. A fifth lane sends a forwarded-clock pattern aligned to the first bit slot of every pixel period.

The mode input chooses how each channel is reduced. In narrow mode the channel's low eight bits are sent. In wide mode the top eight of its ten bits are sent and the two least significant bits are dropped. The mode is sampled with each pixel, so it may change from one pixel to the next.

The fast-clock side is run by a three-state sequencer. SQ_HALT is held while reset is high. It moves to SQ_ARM on the first fast edge with reset low. In SQ_ARM a modulo-7 slot counter runs, but the lanes stay quiet. The sequencer moves to SQ_RUN on the first load strobe (slot counter at 6) after a pixel word has been captured. That transition is also the first load. SQ_RUN then loads all five lane shift registers on every seventh fast edge. Reset from any state returns to SQ_HALT. Reset is a single synchronous input. It must be released so that the pixel clock and the fast clock first sample it low on the same, coincident, rising edge.

Top module: `pxl_ser_tx`

## Requirements
- R1: While reset is high, all four data lanes and the clock lane output 0 from the first fast edge that samples reset high.
- R2: After reset is released, the clock lane and all data lanes stay 0 until slot 0 of the first pixel is sent.
- R3: Once running, the clock lane sends 1,1,0,0,0,1,1 in slots 0 to 6 of every pixel period, with no gap.
- R4: Lane 0 (lane_o[0]) sends, in slots 0 to 6: red bits 0, 1, 2, 3, 4, 5, then green bit 0.
- R5: Lane 1 (lane_o[1]) sends, in slots 0 to 6: green bits 1, 2, 3, 4, 5, then blue bits 0 and 1.
- R6: Lane 2 (lane_o[2]) sends, in slots 0 to 6: blue bits 2, 3, 4, 5, then line valid, frame valid and data valid.
- R7: Lane 3 (lane_o[3]) sends, in slots 0 to 6: red bit 7, green bits 6 and 7, blue bits 6 and 7, exposure enable, then red bit 6.
- R8: With wide_mode_i = 0, channel bits [7:0] are sent as colour bits 7..0, and channel input bits [9:8] have no effect on any lane.
- R9: With wide_mode_i = 1, channel input bits [9:2] are sent as colour bits 7..0, and bits [1:0] have no effect on any lane.
- R10: The pixel captured on the first pixel edge after reset release starts its slot 0 right after the seventh fast edge counted from that pixel edge (that edge being the first). Every later pixel follows exactly one pixel period after the one before, with none dropped or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk_i | input | 1 | Pixel clock; one pixel captured per rising edge |
| fclk_i | input | 1 | Serial clock, seven times pclk_i, phase-locked, rising edges coincident |
| rst_i | input | 1 | Synchronous active-high reset for both clock domains |
| wide_mode_i | input | 1 | 0: send channel bits [7:0]; 1: send channel bits [9:2] |
| red_i | input | CH_W | Red channel |
| grn_i | input | CH_W | Green channel |
| blu_i | input | CH_W | Blue channel |
| frame_vld_i | input | 1 | Frame-valid flag |
| line_vld_i | input | 1 | Line-valid flag |
| data_vld_i | input | 1 | Data-valid flag |
| expo_en_i | input | 1 | Exposure-enable flag |
| lane_o | output | 4 | Serial data lanes, one bit per fast cycle |
| clk_lane_o | output | 1 | Forwarded-clock pattern lane |

## Verification
The bench walks a single one through each of the 24 colour bits and each of the four flags. A design with any two allocation entries swapped, or a lane that sends its slots in reverse, sends a bit in the wrong slot or on the wrong lane, so the per-lane comparison catches it. Narrow-mode pixels carry ones in the unused top bits, and wide-mode pixels carry ones in the discarded low bits, with the mode changing from pixel to pixel. A mode mux that is inverted, or registered one pixel late, therefore shows up as set bits where zeros are expected. The bench also measures the fast-cycle distance from reset release to the first clock-lane pulse, and it checks the idle lanes before that pulse. A sequencer that loads the reset word, or loads one slot early or late, breaks the latency check and shifts every later comparison.

// File: rtl/pxl_ser_pkg.sv
package pxl_ser_pkg;

    localparam int LANES    = 4;
    localparam int SLOTS    = 7;
    localparam int WORD_W   = LANES * SLOTS;
    localparam int IDX_W    = $clog2(WORD_W);
    localparam int SLOT_W   = $clog2(SLOTS);
    localparam int COLOUR_W = 8;

    // Forwarded clock shape, index = slot (symmetric, so order-neutral)
    localparam logic [SLOTS-1:0] CLK_SHAPE = 7'b1100011;

    typedef enum logic [1:0] {
        SQ_HALT,
        SQ_ARM,
        SQ_RUN
    } seq_state_t;

    typedef struct packed {
        logic [COLOUR_W-1:0] red;
        logic [COLOUR_W-1:0] grn;
        logic [COLOUR_W-1:0] blu;
        logic                frame_vld;
        logic                line_vld;
        logic                data_vld;
        logic                expo_en;
    } px_fields_t;

    // Transmit-word bit sent by a lane in a slot (ascending index per lane)
    function automatic logic [IDX_W-1:0] slot_src(input int lane, input int slot);
        logic [IDX_W-1:0] idx;
        case (lane * SLOTS + slot)
            0:  idx = 5'd0;
            1:  idx = 5'd1;
            2:  idx = 5'd2;
            3:  idx = 5'd3;
            4:  idx = 5'd4;
            5:  idx = 5'd6;
            6:  idx = 5'd7;
            7:  idx = 5'd8;
            8:  idx = 5'd9;
            9:  idx = 5'd12;
            10: idx = 5'd13;
            11: idx = 5'd14;
            12: idx = 5'd15;
            13: idx = 5'd18;
            14: idx = 5'd19;
            15: idx = 5'd20;
            16: idx = 5'd21;
            17: idx = 5'd22;
            18: idx = 5'd24;
            19: idx = 5'd25;
            20: idx = 5'd26;
            21: idx = 5'd5;
            22: idx = 5'd10;
            23: idx = 5'd11;
            24: idx = 5'd16;
            25: idx = 5'd17;
            26: idx = 5'd23;
            27: idx = 5'd27;
            default: idx = '0;
        endcase
        return idx;
    endfunction

    // Place colour bits and flags at their transmit-word positions
    function automatic logic [WORD_W-1:0] alloc_word(input px_fields_t f);
        logic [WORD_W-1:0] w;
        w = '0;
        w[4:0]   = f.red[4:0];
        w[6]     = f.red[5];
        w[27]    = f.red[6];
        w[5]     = f.red[7];
        w[9:7]   = f.grn[2:0];
        w[14:12] = f.grn[5:3];
        w[10]    = f.grn[6];
        w[11]    = f.grn[7];
        w[15]    = f.blu[0];
        w[22:18] = f.blu[5:1];
        w[16]    = f.blu[6];
        w[17]    = f.blu[7];
        w[23]    = f.expo_en;
        w[24]    = f.line_vld;
        w[25]    = f.frame_vld;
        w[26]    = f.data_vld;
        return w;
    endfunction

endpackage

// File: rtl/pxl_ser_pack.sv
module pxl_ser_pack
    import pxl_ser_pkg::*;
#(
    parameter int CH_W = 10
) (
    input  logic              pclk_i,
    input  logic              rst_i,
    input  logic              wide_mode_i,
    input  logic [CH_W-1:0]   red_i,
    input  logic [CH_W-1:0]   grn_i,
    input  logic [CH_W-1:0]   blu_i,
    input  logic              frame_vld_i,
    input  logic              line_vld_i,
    input  logic              data_vld_i,
    input  logic              expo_en_i,
    output logic [WORD_W-1:0] word_o,
    output logic              primed_o
);

    localparam int DROP_W = CH_W - COLOUR_W;

    px_fields_t fields;

    function automatic logic [COLOUR_W-1:0] reduce(input logic [CH_W-1:0] v,
                                                   input logic wide);
        return wide ? v[CH_W-1:DROP_W] : v[COLOUR_W-1:0];
    endfunction

    always_comb begin
        fields.red       = reduce(red_i, wide_mode_i);
        fields.grn       = reduce(grn_i, wide_mode_i);
        fields.blu       = reduce(blu_i, wide_mode_i);
        fields.frame_vld = frame_vld_i;
        fields.line_vld  = line_vld_i;
        fields.data_vld  = data_vld_i;
        fields.expo_en   = expo_en_i;
    end

    always_ff @(posedge pclk_i) begin
        if (rst_i) begin
            word_o   <= '0;
            primed_o <= 1'b0;
        end else begin
            word_o   <= alloc_word(fields);
            primed_o <= 1'b1;
        end
    end

endmodule

// File: rtl/pxl_ser_seq.sv
module pxl_ser_seq
    import pxl_ser_pkg::*;
(
    input  logic fclk_i,
    input  logic rst_i,
    input  logic primed_i,
    output logic load_o
);

    seq_state_t          state_q;
    seq_state_t          state_d;
    logic [SLOT_W-1:0]   slot_q;
    logic                strobe;

    assign strobe = (slot_q == SLOT_W'(SLOTS - 1));

    always_ff @(posedge fclk_i) begin
        if (rst_i) begin
            slot_q <= '0;
        end else if (strobe) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_q + 1'b1;
        end
    end

    always_ff @(posedge fclk_i) begin
        if (rst_i) begin
            state_q <= SQ_HALT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_HALT: state_d = SQ_ARM;
            SQ_ARM:  if (strobe && primed_i) state_d = SQ_RUN;
            SQ_RUN:  state_d = SQ_RUN;
            default: state_d = SQ_HALT;
        endcase
    end

    always_comb begin
        load_o = 1'b0;
        unique case (state_q)
            SQ_HALT: load_o = 1'b0;
            SQ_ARM:  load_o = strobe && primed_i;
            SQ_RUN:  load_o = strobe;
            default: load_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/pxl_ser_lane.sv
module pxl_ser_lane
    import pxl_ser_pkg::*;
(
    input  logic             fclk_i,
    input  logic             rst_i,
    input  logic             load_i,
    input  logic [SLOTS-1:0] par_i,
    output logic             ser_o
);

    logic [SLOTS-1:0] shreg_q;

    always_ff @(posedge fclk_i) begin
        if (rst_i) begin
            shreg_q <= '0;
        end else if (load_i) begin
            shreg_q <= par_i;
        end else begin
            shreg_q <= {1'b0, shreg_q[SLOTS-1:1]};
        end
    end

    assign ser_o = shreg_q[0];

endmodule

// File: rtl/pxl_ser_tx.sv
module pxl_ser_tx
    import pxl_ser_pkg::*;
#(
    parameter int CH_W = 10
) (
    input  logic            pclk_i,
    input  logic            fclk_i,
    input  logic            rst_i,
    input  logic            wide_mode_i,
    input  logic [CH_W-1:0] red_i,
    input  logic [CH_W-1:0] grn_i,
    input  logic [CH_W-1:0] blu_i,
    input  logic            frame_vld_i,
    input  logic            line_vld_i,
    input  logic            data_vld_i,
    input  logic            expo_en_i,
    output logic [LANES-1:0] lane_o,
    output logic            clk_lane_o
);

    logic [WORD_W-1:0] word_q;
    logic              primed_q;
    logic              load_w;

    pxl_ser_pack #(.CH_W(CH_W)) pack_i (
        .pclk_i      (pclk_i),
        .rst_i       (rst_i),
        .wide_mode_i (wide_mode_i),
        .red_i       (red_i),
        .grn_i       (grn_i),
        .blu_i       (blu_i),
        .frame_vld_i (frame_vld_i),
        .line_vld_i  (line_vld_i),
        .data_vld_i  (data_vld_i),
        .expo_en_i   (expo_en_i),
        .word_o      (word_q),
        .primed_o    (primed_q)
    );

    pxl_ser_seq seq_i (
        .fclk_i   (fclk_i),
        .rst_i    (rst_i),
        .primed_i (primed_q),
        .load_o   (load_w)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [SLOTS-1:0] par;
        always_comb begin
            for (int s = 0; s < SLOTS; s++) begin
                par[s] = word_q[slot_src(l, s)];
            end
        end
        pxl_ser_lane lane_i (
            .fclk_i (fclk_i),
            .rst_i  (rst_i),
            .load_i (load_w),
            .par_i  (par),
            .ser_o  (lane_o[l])
        );
    end

    pxl_ser_lane clk_lane_i (
        .fclk_i (fclk_i),
        .rst_i  (rst_i),
        .load_i (load_w),
        .par_i  (CLK_SHAPE),
        .ser_o  (clk_lane_o)
    );

endmodule

// File: rtl/pxl_ser_tx_chk.sv
module pxl_ser_tx_chk
    import pxl_ser_pkg::*;
(
    input logic             fclk_i,
    input logic             rst_i,
    input logic [LANES-1:0] lane_o,
    input logic             clk_lane_o,
    input logic             load_w
);

    logic       rst_seen_q;
    logic       started_q;
    logic       loaded_q;
    logic [3:0] gap_q;

    always_ff @(posedge fclk_i) rst_seen_q <= rst_i;

    always_ff @(posedge fclk_i) begin
        if (rst_i) begin
            started_q <= 1'b0;
            loaded_q  <= 1'b0;
            gap_q     <= '0;
        end else begin
            if (clk_lane_o) started_q <= 1'b1;
            if (load_w) begin
                loaded_q <= 1'b1;
                gap_q    <= '0;
            end else if (gap_q != 4'd15) begin
                gap_q <= gap_q + 1'b1;
            end
        end
    end

    // R1: outputs quiet once reset has been sampled
    always @(negedge fclk_i) begin
        if (rst_seen_q === 1'b1) begin
            p_reset_quiet_r1: assert (lane_o == '0 && clk_lane_o == 1'b0)
                else $error("p_reset_quiet_r1");
        end
    end

    // R2: data lanes silent until clock lane first pulses
    p_quiet_until_start_r2: assert property (@(posedge fclk_i) disable iff (rst_i)
        (!started_q && !clk_lane_o) |-> (lane_o == '0));

    // R3: clock lane shape after each falling edge
    p_clk_shape_r3: assert property (@(posedge fclk_i) disable iff (rst_i)
        $fell(clk_lane_o) |=> !clk_lane_o ##1 !clk_lane_o ##1 clk_lane_o ##1 clk_lane_o
                              ##1 clk_lane_o ##1 clk_lane_o ##1 !clk_lane_o);

    // R10: loads come exactly one pixel period apart
    p_load_spacing_r10: assert property (@(posedge fclk_i) disable iff (rst_i)
        (load_w && loaded_q) |-> (gap_q == 4'd6));

    // R10: no second load inside a pixel period
    p_no_early_load_r10: assert property (@(posedge fclk_i) disable iff (rst_i)
        load_w |=> !load_w);

endmodule

bind pxl_ser_tx pxl_ser_tx_chk chk_i (
    .fclk_i     (fclk_i),
    .rst_i      (rst_i),
    .lane_o     (lane_o),
    .clk_lane_o (clk_lane_o),
    .load_w     (load_w)
);

// File: tb/pxl_ser_tx_tb_top.sv
module pxl_ser_tx_tb_top;

    logic       fclk = 1'b0;
    logic       pclk = 1'b0;
    logic       rst  = 1'b1;
    logic       wide = 1'b0;
    logic [9:0] red = '0, grn = '0, blu = '0;
    logic       fv = 1'b0, lv = 1'b0, dv = 1'b0, ee = 1'b0;
    logic [3:0] lane_o;
    logic       clk_lane_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    bit finished = 1'b0;

    typedef struct {
        logic [3:0][6:0] lanes;
        string           tag;
    } item_t;
    item_t q[$];

    pxl_ser_tx dut_i (
        .pclk_i      (pclk),
        .fclk_i      (fclk),
        .rst_i       (rst),
        .wide_mode_i (wide),
        .red_i       (red),
        .grn_i       (grn),
        .blu_i       (blu),
        .frame_vld_i (fv),
        .line_vld_i  (lv),
        .data_vld_i  (dv),
        .expo_en_i   (ee),
        .lane_o      (lane_o),
        .clk_lane_o  (clk_lane_o)
    );

    // 250 MHz fast clock, pixel clock one seventh, rising edges coincide
    initial begin
        forever begin
            for (int k = 0; k < 14; k++) begin
                fclk = (k % 2 == 0);
                pclk = (k < 7);
                #2;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected lane bits built from R4..R7, channel reduction from R8/R9
    function automatic logic [3:0][6:0] exp_lanes(input bit w, input logic [9:0] r10,
            input logic [9:0] g10, input logic [9:0] b10, input bit f, input bit l,
            input bit d, input bit e);
        logic [7:0] r, g, b;
        logic [3:0][6:0] x;
        r = w ? r10[9:2] : r10[7:0];
        g = w ? g10[9:2] : g10[7:0];
        b = w ? b10[9:2] : b10[7:0];
        x[0] = {g[0], r[5], r[4], r[3], r[2], r[1], r[0]};
        x[1] = {b[1], b[0], g[5], g[4], g[3], g[2], g[1]};
        x[2] = {d, f, l, b[5], b[4], b[3], b[2]};
        x[3] = {r[6], e, b[7], b[6], g[7], g[6], r[7]};
        return x;
    endfunction

    task automatic send_px(input bit w, input logic [9:0] r10, input logic [9:0] g10,
            input logic [9:0] b10, input bit f, input bit l, input bit d, input bit e,
            input string tag);
        item_t it;
        wide = w; red = r10; grn = g10; blu = b10;
        fv = f; lv = l; dv = d; ee = e;
        it.lanes = exp_lanes(w, r10, g10, b10, f, l, d, e);
        it.tag   = tag;
        q.push_back(it);
    endtask

    // Monitor / scoreboard
    int unsigned     rel_cnt = 0;
    bit              synced  = 1'b0;
    int              slot    = 0;
    logic [3:0][6:0] got;
    logic [6:0]      got_clk;

    always @(posedge fclk) begin
        if (rst) rel_cnt <= 0;
        else     rel_cnt <= rel_cnt + 1;
    end

    always @(negedge fclk) begin
        if (rst) begin
            synced = 1'b0;
        end else if (!done) begin
            if (!synced && !clk_lane_o) begin
                chk(lane_o == 4'b0, "R2 lanes idle before first slot", 32'(lane_o), 0);
            end else begin
                if (!synced) begin
                    synced = 1'b1;
                    slot = 0;
                    chk(rel_cnt == 7, "R10 first slot latency", rel_cnt, 7);
                end
                for (int l = 0; l < 4; l++) got[l][slot] = lane_o[l];
                got_clk[slot] = clk_lane_o;
                if (slot == 6) begin
                    item_t it;
                    slot = 0;
                    chk(got_clk == 7'b1100011, "R3 clock lane shape", 32'(got_clk),
                        32'h63);
                    if (q.size() == 0) begin
                        chk(1'b0, "R10 word with no pixel sent", 32'(got), 0);
                    end else begin
                        it = q.pop_front();
                        chk(got[0] == it.lanes[0], {"R4 lane0 ", it.tag},
                            32'(got[0]), 32'(it.lanes[0]));
                        chk(got[1] == it.lanes[1], {"R5 lane1 ", it.tag},
                            32'(got[1]), 32'(it.lanes[1]));
                        chk(got[2] == it.lanes[2], {"R6 lane2 ", it.tag},
                            32'(got[2]), 32'(it.lanes[2]));
                        chk(got[3] == it.lanes[3], {"R7 lane3 ", it.tag},
                            32'(got[3]), 32'(it.lanes[3]));
                    end
                end else begin
                    slot = slot + 1;
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge fclk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=0", q.size());
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset quiet
        repeat (3) @(negedge pclk);
        for (int i = 0; i < 4; i++) begin
            @(negedge fclk);
            chk(lane_o == 4'b0 && clk_lane_o == 1'b0, "R1 outputs in reset",
                {27'b0, clk_lane_o, lane_o}, 0);
        end
        @(negedge pclk);
        send_px(1'b0, 10'h300, 10'h300, 10'h300, 1'b0, 1'b0, 1'b0, 1'b0, "R8 hi-only");
        #11;
        rst = 1'b0;

        // R4-R7 walking one through every colour bit, junk in [9:8] (R8)
        for (int i = 0; i < 8; i++) begin
            @(negedge pclk);
            send_px(1'b0, 10'h300 | (10'h1 << i), 10'h300, 10'h300, 0, 0, 0, 0, "R8 red");
        end
        for (int i = 0; i < 8; i++) begin
            @(negedge pclk);
            send_px(1'b0, 10'h200, 10'h100 | (10'h1 << i), 10'h000, 0, 0, 0, 0, "R8 grn");
        end
        for (int i = 0; i < 8; i++) begin
            @(negedge pclk);
            send_px(1'b0, 10'h000, 10'h000, 10'h300 | (10'h1 << i), 0, 0, 0, 0, "R8 blu");
        end
        // Flags alone
        @(negedge pclk); send_px(1'b0, 10'h0, 10'h0, 10'h0, 1, 0, 0, 0, "R6 frame");
        @(negedge pclk); send_px(1'b0, 10'h0, 10'h0, 10'h0, 0, 1, 0, 0, "R6 line");
        @(negedge pclk); send_px(1'b0, 10'h0, 10'h0, 10'h0, 0, 0, 1, 0, "R6 data");
        @(negedge pclk); send_px(1'b0, 10'h0, 10'h0, 10'h0, 0, 0, 0, 1, "R7 expo");
        // Dense patterns
        @(negedge pclk); send_px(1'b0, 10'h0FF, 10'h0FF, 10'h0FF, 1, 1, 1, 1, "R8 ones");
        @(negedge pclk); send_px(1'b0, 10'h0A5, 10'h05A, 10'h03C, 1, 0, 1, 0, "R8 mix");
        // R9 wide mode: low bits discarded, mode toggles pixel to pixel
        @(negedge pclk); send_px(1'b1, 10'h003, 10'h003, 10'h003, 0, 0, 0, 0, "R9 low-only");
        @(negedge pclk); send_px(1'b1, 10'h2AB, 10'h155, 10'h3FC, 0, 1, 1, 0, "R9 mix");
        @(negedge pclk); send_px(1'b0, 10'h2AB, 10'h155, 10'h3FC, 0, 1, 1, 0, "R8 same");
        @(negedge pclk); send_px(1'b1, 10'h3FF, 10'h000, 10'h203, 1, 0, 0, 1, "R9 edge");
        for (int i = 2; i < 10; i++) begin
            @(negedge pclk);
            send_px(1'b1, (10'h1 << i) | 10'h3, 10'h2, 10'h1 << i, 0, 0, 0, 0, "R9 walk");
        end
        @(negedge pclk); send_px(1'b0, 10'h000, 10'h000, 10'h000, 0, 0, 0, 0, "R10 last");

        // Wait until every pushed pixel has been compared
        while (q.size() != 0) @(negedge fclk);
        done = 1'b1;
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule